// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the fetch address of a small processor core whose program space is 16K words, split into 16 pages of 1K words. Each cycle it takes decoded control strobes from the instruction decoder (jump, call, return, computed jump by move or add, table lookup, software interrupt, hardware interrupt, page set and plain advance), a 10-bit literal and an 8-bit accumulator value. It computes the next 14-bit fetch address. An internal 4-bit page register supplies the upper address bits for the instructions that take them from it. An 8-level circular return stack keeps the return addresses.

A two-state control machine sits in front of the address register. `ST_RESET` is entered while `rst_n` is low and lasts for the first clock after release. In that state every strobe is ignored and the fetch address stays at the reset vector. The transition `ST_RESET -> ST_RUN` is taken on that first clock. `ST_RUN` then loops on itself until the next reset. In `ST_RUN` the strobes are resolved by a fixed priority into one action, and the address register and page register take the result on the clock edge.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low the fetch address is 0x0000, the page register is 0 and every stack entry is 0. On the first clock after release the block moves from ST_RESET to ST_RUN, ignores all strobes and keeps the fetch address at 0x0000.
- R2: A jump loads address bits 9..0 from the literal and bits 13..10 from the page register.
- R3: A call pushes the 14-bit address of the next instruction (fetch address + 1, wrapping 0x3FFF to 0x0000) and then loads the address as a jump does.
- R4: A return loads the fetch address from the top stack entry and pops it. This single strobe covers plain return, return with literal and return from interrupt.
- R5: A move to the PC yields {page, 2'b00, acc}.
- R6: An add to the PC yields {page, 2'b00, low byte of (fetch+1) plus acc}. The carry out of the byte is discarded.
- R7: A table lookup yields {bits 13..8 of (fetch+1), low byte of (fetch+1) plus acc}. The page register is not used and the carry is discarded.
- R8: A software interrupt jumps to 0x0001 and a hardware interrupt to 0x0008. Both push fetch+1 as a call does.
- R9: A page set writes literal bits 3..0 into the page register and advances the fetch address by one. The new page appears in the next jump.
- R10: With no strobe, `adv` high advances the fetch address by one and wraps 0x3FFF to 0x0000. With `adv` low the address holds.
- R11: The stack is circular with 8 entries. A ninth push overwrites the oldest entry. A pop from an empty stack returns whatever the slot below the pointer holds.
- R12: When several strobes are high together, exactly one action is taken, in this order: hardware interrupt, software interrupt, call, jump, return, move, add, table, page set, advance. Strobes that lose have no effect, including a page set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Instruction finished; advance by one |
| jmp_en | input | 1 | Jump strobe |
| call_en | input | 1 | Call strobe |
| ret_en | input | 1 | Return strobe |
| movpc_en | input | 1 | Move accumulator to PC strobe |
| addpc_en | input | 1 | Add accumulator to PC strobe |
| tbl_en | input | 1 | Table lookup strobe |
| swi_en | input | 1 | Software interrupt strobe |
| irq_en | input | 1 | Hardware interrupt strobe |
| page_en | input | 1 | Page-set strobe |
| lit | input | 10 | Instruction literal |
| acc | input | 8 | Accumulator value |
| fetch_addr | output | 14 | Current fetch address |

## Verification
The hardest condition to reach from the ports is a stack that has wrapped. Getting there needs nine nested calls with no return in between, followed by more returns than the stack can hold. The bench gives each of the nine calls a distinct literal, so every pushed return address is unique. It then issues nine returns and checks that the eighth return lands on the second call's return address. It also checks that the ninth return reads the newest entry again. Carry discard and the 0x3FFF wrap need the address placed at a page edge. The bench does this with a page set to 15 and a jump to literal 0x3FF.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic {
        ST_RESET,
        ST_RUN
    } seq_state_t;

    typedef enum logic [3:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_PAGE,
        ACT_TBL,
        ACT_ADD,
        ACT_MOV,
        ACT_RET,
        ACT_JMP,
        ACT_CALL,
        ACT_SWI,
        ACT_IRQ
    } seq_act_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
    import pcseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  logic     jmp_en,
    input  logic     call_en,
    input  logic     ret_en,
    input  logic     movpc_en,
    input  logic     addpc_en,
    input  logic     tbl_en,
    input  logic     swi_en,
    input  logic     irq_en,
    input  logic     page_en,
    output seq_act_t act,
    output logic     running,
    output logic     push,
    output logic     pop
);

    seq_state_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RESET: st_d = ST_RUN;
            ST_RUN:   st_d = ST_RUN;
        endcase
    end

    // outputs: fixed-priority action select
    always_comb begin
        act     = ACT_HOLD;
        running = 1'b0;
        unique case (st_q)
            ST_RESET: act = ACT_HOLD;
            ST_RUN: begin
                running = 1'b1;
                if      (irq_en)   act = ACT_IRQ;
                else if (swi_en)   act = ACT_SWI;
                else if (call_en)  act = ACT_CALL;
                else if (jmp_en)   act = ACT_JMP;
                else if (ret_en)   act = ACT_RET;
                else if (movpc_en) act = ACT_MOV;
                else if (addpc_en) act = ACT_ADD;
                else if (tbl_en)   act = ACT_TBL;
                else if (page_en)  act = ACT_PAGE;
                else if (adv)      act = ACT_STEP;
                else               act = ACT_HOLD;
            end
        endcase
        push = (act == ACT_CALL) || (act == ACT_SWI) || (act == ACT_IRQ);
        pop  = (act == ACT_RET);
    end

    // R1: the cycle right after reset release never carries an action
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESET) |-> (!push && !pop));

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] top
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] top_idx;
    logic [WIDTH-1:0] slot [DEPTH];

    assign top_idx = sp_q - PTR_W'(1);
    assign top     = slot[top_idx];

    // pointer wraps modulo DEPTH: oldest entry is overwritten, empty pop is stale
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sp_q <= '0;
        else if (push) sp_q <= sp_q + PTR_W'(1);
        else if (pop)  sp_q <= top_idx;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               slot[g] <= '0;
            else if (push && (sp_q == PTR_W'(g)))     slot[g] <= din;
        end
    end

    // R3: a pushed value is visible at the top on the next cycle
    assert_push_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top == $past(din)));

    // R11: a push directly followed by a pop restores the prior top
    assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) ##1 (pop && !push) |=> (top == $past(top, 2)));

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int unsigned PAGE_W  = 4,
    parameter int unsigned OFFS_W  = 10,
    parameter int unsigned ACC_W   = 8,
    parameter int unsigned SWI_VEC = 1,
    parameter int unsigned IRQ_VEC = 8
) (
    input  seq_act_t                   act,
    input  logic [PAGE_W+OFFS_W-1:0]   pc,
    input  logic [PAGE_W-1:0]          page,
    input  logic [OFFS_W-1:0]          lit,
    input  logic [ACC_W-1:0]           acc,
    input  logic [PAGE_W+OFFS_W-1:0]   stack_top,
    output logic [PAGE_W+OFFS_W-1:0]   nxt_pc,
    output logic [PAGE_W+OFFS_W-1:0]   ret_addr
);

    localparam int unsigned PC_W = PAGE_W + OFFS_W;
    localparam int unsigned HI_W = OFFS_W - ACC_W;

    logic [PC_W-1:0]  seq;
    logic [ACC_W-1:0] low_sum;
    logic [PC_W-1:0]  far_tgt;
    logic [PC_W-1:0]  mov_tgt;
    logic [PC_W-1:0]  add_tgt;
    logic [PC_W-1:0]  tbl_tgt;

    assign seq      = pc + PC_W'(1);
    assign ret_addr = seq;
    assign low_sum  = seq[ACC_W-1:0] + acc;
    assign far_tgt  = {page, lit};
    assign mov_tgt  = {page, {HI_W{1'b0}}, acc};
    assign add_tgt  = {page, {HI_W{1'b0}}, low_sum};
    assign tbl_tgt  = {seq[PC_W-1:ACC_W], low_sum};

    always_comb begin
        unique case (act)
            ACT_HOLD: nxt_pc = pc;
            ACT_STEP: nxt_pc = seq;
            ACT_PAGE: nxt_pc = seq;
            ACT_TBL:  nxt_pc = tbl_tgt;
            ACT_ADD:  nxt_pc = add_tgt;
            ACT_MOV:  nxt_pc = mov_tgt;
            ACT_RET:  nxt_pc = stack_top;
            ACT_JMP:  nxt_pc = far_tgt;
            ACT_CALL: nxt_pc = far_tgt;
            ACT_SWI:  nxt_pc = PC_W'(SWI_VEC);
            ACT_IRQ:  nxt_pc = PC_W'(IRQ_VEC);
            default:  nxt_pc = pc;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int unsigned PAGE_W  = 4,
    parameter int unsigned OFFS_W  = 10,
    parameter int unsigned ACC_W   = 8,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned SWI_VEC = 1,
    parameter int unsigned IRQ_VEC = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    input  logic                      jmp_en,
    input  logic                      call_en,
    input  logic                      ret_en,
    input  logic                      movpc_en,
    input  logic                      addpc_en,
    input  logic                      tbl_en,
    input  logic                      swi_en,
    input  logic                      irq_en,
    input  logic                      page_en,
    input  logic [OFFS_W-1:0]         lit,
    input  logic [ACC_W-1:0]          acc,
    output logic [PAGE_W+OFFS_W-1:0]  fetch_addr
);

    localparam int unsigned PC_W = PAGE_W + OFFS_W;

    seq_act_t          act;
    logic              running;
    logic              push;
    logic              pop;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   nxt_pc;
    logic [PC_W-1:0]   ret_addr;
    logic [PC_W-1:0]   stk_top;
    logic [PAGE_W-1:0] page_q;
    logic              any_cmd;

    pcseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .jmp_en   (jmp_en),
        .call_en  (call_en),
        .ret_en   (ret_en),
        .movpc_en (movpc_en),
        .addpc_en (addpc_en),
        .tbl_en   (tbl_en),
        .swi_en   (swi_en),
        .irq_en   (irq_en),
        .page_en  (page_en),
        .act      (act),
        .running  (running),
        .push     (push),
        .pop      (pop)
    );

    pcseq_target #(
        .PAGE_W  (PAGE_W),
        .OFFS_W  (OFFS_W),
        .ACC_W   (ACC_W),
        .SWI_VEC (SWI_VEC),
        .IRQ_VEC (IRQ_VEC)
    ) u_target (
        .act       (act),
        .pc        (pc_q),
        .page      (page_q),
        .lit       (lit),
        .acc       (acc),
        .stack_top (stk_top),
        .nxt_pc    (nxt_pc),
        .ret_addr  (ret_addr)
    );

    pcseq_stack #(
        .DEPTH (DEPTH),
        .WIDTH (PC_W)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (ret_addr),
        .top   (stk_top)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            page_q <= '0;
        end else begin
            pc_q <= nxt_pc;
            if (act == ACT_PAGE) page_q <= lit[PAGE_W-1:0];
        end
    end

    assign fetch_addr = pc_q;

    assign any_cmd = jmp_en | call_en | ret_en | movpc_en | addpc_en |
                     tbl_en | swi_en | irq_en | page_en;

    // R1: no movement out of the reset vector during the first cycle after release
    assert_reset_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (fetch_addr == '0));

    // R2: a winning jump lands on {page, literal}
    assert_jump_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && jmp_en && !irq_en && !swi_en && !call_en)
        |=> (fetch_addr == {$past(page_q), $past(lit)}));

    // R4: a winning return lands on the previous top of stack
    assert_ret_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ret_en && !irq_en && !swi_en && !call_en && !jmp_en)
        |=> (fetch_addr == $past(stk_top)));

    // R8: hardware interrupt always wins and vectors
    assert_irq_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && irq_en) |=> (fetch_addr == PC_W'(IRQ_VEC)));

    // R10: plain advance adds one with wrap
    assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && adv && !any_cmd) |=> (fetch_addr == $past(fetch_addr) + PC_W'(1)));

    // R10: no strobe and no advance holds the address
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !adv && !any_cmd) |=> $stable(fetch_addr));

endmodule

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv, jmp_en, call_en, ret_en, movpc_en, addpc_en;
    logic        tbl_en, swi_en, irq_en, page_en;
    logic [9:0]  lit;
    logic [7:0]  acc;
    logic [13:0] fetch_addr;

    int checks = 0;
    int fails  = 0;

    localparam int K_JMP  = 0;
    localparam int K_CALL = 1;
    localparam int K_RET  = 2;
    localparam int K_MOV  = 3;
    localparam int K_ADD  = 4;
    localparam int K_TBL  = 5;
    localparam int K_SWI  = 6;
    localparam int K_IRQ  = 7;
    localparam int K_PAGE = 8;
    localparam int K_ADV  = 9;

    always #2.5 clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .jmp_en(jmp_en), .call_en(call_en),
        .ret_en(ret_en), .movpc_en(movpc_en), .addpc_en(addpc_en), .tbl_en(tbl_en),
        .swi_en(swi_en), .irq_en(irq_en), .page_en(page_en), .lit(lit), .acc(acc),
        .fetch_addr(fetch_addr)
    );

    task automatic idle();
        adv = 0; jmp_en = 0; call_en = 0; ret_en = 0; movpc_en = 0; addpc_en = 0;
        tbl_en = 0; swi_en = 0; irq_en = 0; page_en = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [13:0] exp);
        checks++;
        if (fetch_addr !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, fetch_addr, exp);
        end
    endtask

    task automatic fire(input int kind, input logic [9:0] l, input logic [7:0] a);
        idle();
        lit = l;
        acc = a;
        case (kind)
            K_JMP:   jmp_en   = 1;
            K_CALL:  call_en  = 1;
            K_RET:   ret_en   = 1;
            K_MOV:   movpc_en = 1;
            K_ADD:   addpc_en = 1;
            K_TBL:   tbl_en   = 1;
            K_SWI:   swi_en   = 1;
            K_IRQ:   irq_en   = 1;
            K_PAGE:  page_en  = 1;
            default: adv      = 1;
        endcase
        cyc();
        idle();
    endtask

    task automatic t_reset();
        idle(); lit = '0; acc = '0; rst_n = 0;
        repeat (3) cyc();
        chk("R1 reset value", 14'h0000);
        rst_n = 1; jmp_en = 1; lit = 10'h155;
        cyc();
        chk("R1 first cycle ignores strobes", 14'h0000);
        fire(K_RET, 0, 0);
        chk("R11 empty pop returns cleared slot", 14'h0000);
        fire(K_ADV, 0, 0);
        chk("R10 advance", 14'h0001);
        cyc();
        chk("R10 hold without adv", 14'h0001);
    endtask

    task automatic t_page_jump();
        fire(K_PAGE, 10'h005, 0);
        chk("R9 page set advances", 14'h0002);
        fire(K_JMP, 10'h2AB, 0);
        chk("R2 jump uses page", 14'h16AB);
    endtask

    task automatic t_call_ret();
        fire(K_CALL, 10'h010, 0);
        chk("R3 call target", 14'h1410);
        fire(K_RET, 0, 0);
        chk("R4 return to pushed pc+1", 14'h16AC);
    endtask

    task automatic t_move_add();
        fire(K_MOV, 0, 8'hC3);
        chk("R5 move to pc", 14'h14C3);
        fire(K_JMP, 10'h3F0, 0);
        chk("R2 jump high offset", 14'h17F0);
        fire(K_ADD, 0, 8'h20);
        chk("R6 add clears bits 9..8, drops carry", 14'h1411);
    endtask

    task automatic t_table();
        fire(K_JMP, 10'h3F0, 0);
        fire(K_TBL, 0, 8'h20);
        chk("R7 table keeps upper bits, drops carry", 14'h1711);
        fire(K_JMP, 10'h3F0, 0);
        fire(K_PAGE, 10'h002, 0);
        chk("R9 page set step", 14'h17F1);
        fire(K_TBL, 0, 8'h05);
        chk("R7 table ignores page register", 14'h17F7);
    endtask

    task automatic t_vectors();
        fire(K_SWI, 0, 0);
        chk("R8 software vector", 14'h0001);
        fire(K_IRQ, 0, 0);
        chk("R8 hardware vector", 14'h0008);
        fire(K_RET, 0, 0);
        chk("R8 hardware push", 14'h0002);
        fire(K_RET, 0, 0);
        chk("R8 software push", 14'h17F8);
    endtask

    task automatic t_wrap();
        fire(K_PAGE, 10'h00F, 0);
        fire(K_JMP, 10'h3FF, 0);
        chk("R2 top of space", 14'h3FFF);
        fire(K_ADV, 0, 0);
        chk("R10 wrap to zero", 14'h0000);
        fire(K_JMP, 10'h3FF, 0);
        fire(K_CALL, 10'h000, 0);
        chk("R3 call from top", 14'h3C00);
        fire(K_RET, 0, 0);
        chk("R3 pushed address wraps", 14'h0000);
    endtask

    task automatic t_priority();
        fire(K_PAGE, 10'h000, 0);
        chk("R9 page back to zero", 14'h0001);
        adv = 1; jmp_en = 1; call_en = 1; ret_en = 1; movpc_en = 1; addpc_en = 1;
        tbl_en = 1; swi_en = 1; irq_en = 1; page_en = 1; lit = 10'h123; acc = 8'h44;
        cyc(); idle();
        chk("R12 interrupt wins", 14'h0008);
        adv = 1; jmp_en = 1; ret_en = 1; movpc_en = 1; addpc_en = 1;
        tbl_en = 1; page_en = 1; lit = 10'h123; acc = 8'h44;
        cyc(); idle();
        chk("R12 jump beats lower strobes", 14'h0123);
        fire(K_JMP, 10'h000, 0);
        chk("R12 losing page set has no effect", 14'h0000);
        fire(K_RET, 0, 0);
        chk("R12 interrupt had pushed", 14'h0002);
        adv = 1; movpc_en = 1; addpc_en = 1; tbl_en = 1; page_en = 1;
        lit = 10'h00A; acc = 8'h44;
        cyc(); idle();
        chk("R12 move beats add and table", 14'h0044);
    endtask

    task automatic t_stack_wrap();
        for (int i = 1; i <= 9; i++) begin
            fire(K_CALL, 10'(i * 32), 0);
            chk("R11 nested call target", 14'(i * 32));
        end
        for (int j = 9; j >= 2; j--) begin
            fire(K_RET, 0, 0);
            chk("R11 wrapped pop order", 14'((j - 1) * 32 + 1));
        end
        fire(K_RET, 0, 0);
        chk("R11 oldest overwritten, stale reread", 14'h0101);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_page_jump();
        t_call_ret();
        t_move_add();
        t_table();
        t_vectors();
        t_wrap();
        t_priority();
        t_stack_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule